// File: doc/BRIEF.md
# Delay Memory Zero and Self-Test Controller

This block runs bulk operations on a 14-bit-wide delay memory whose depth is set by a parameter. The nominal depth is 32K words. It can run two kinds of bulk operation, and it also gates the normal single-word reads and writes that reach the memory. A zeroing sweep clears every word. A self test writes an alternating checkerboard over the whole memory, then reads every word back and compares it with the expected value. The memory itself sits outside the block, on a plain address, write-data, write-enable and read-data port with one clock of read latency.

A zeroing sweep starts in three cases: after reset, on a program change while internal mode is selected, and for as long as the zero request input is held. Once a sweep has started, it runs to the end even if the request drops. Only the cancel input can stop it part way. The cancel input also holds off any new sweep while it is high. After a sweep finishes, no new sweep may start during a lockout window that stands for one word-clock period. A self test is requested with a one-cycle pulse. The request stays visible on an output until the test ends. A running test cannot be stopped. While either operation runs, the busy output is high and normal accesses are dropped. A ready flag goes low when any operation starts and goes high when it ends. A pass flag holds the result of the last self test.

Top module: `dmz_sweep_ctrl`

## Requirements
- R1: Reset leaves busy, ready and pass low. A zeroing sweep starts at the first clock edge after reset is released.
- R2: A zeroing sweep writes 0 to every address from 0 upward, taking two clocks per address. It keeps busy high for exactly 2*DEPTH cycles and finishes even if zero_req falls while it runs.
- R3: While zero_req is held high, sweeps repeat. Between the end of one sweep and the start of the next, busy stays low for exactly LOCK_CYC+1 cycles. No sweep starts once zero_req is low.
- R4: If zero_cancel is high during a sweep, busy falls one cycle later and no further addresses are written. While zero_cancel is high, no sweep starts, even with zero_req high. A sweep starts on the first edge after zero_cancel drops, provided zero_req is still high.
- R5: The self test uses test_pat, sampled when the test starts. With test_pat=1, even addresses receive 0x2AAA and odd addresses receive 0x1555. With test_pat=0, even addresses receive 0x1555 and odd addresses receive 0x2AAA.
- R6: A pulse on test_go sets test_pending. The test starts two edges after the pulse and keeps busy high for exactly 4*DEPTH+2 cycles. Neither zero_cancel nor zero_req stops it. test_pending clears when the test ends.
- R7: pass reads 0 throughout a test. At the end it reads 1 only if every address read back its expected pattern.
- R8: A user_wr or user_rd that arrives while busy is high, or in the cycle in which an operation starts, is dropped. The memory is not written and user_rdata keeps its value.
- R9: An accepted user access drives the memory port one edge later. Three edges after acceptance, ready is high again, and for a read user_rdata holds the addressed word.
- R10: A prog_change pulse starts a zeroing sweep two edges later when int_mode=1. It has no effect when int_mode=0.
- R11: ready is low while busy is high. It rises when a sweep, a test or an access completes. After a cancelled sweep it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| int_mode | input | 1 | 1 selects internal program mode |
| prog_change | input | 1 | One-cycle program change event |
| zero_req | input | 1 | Zeroing request, level sensitive |
| zero_cancel | input | 1 | Aborts a sweep and blocks new sweeps |
| test_go | input | 1 | One-cycle self-test request |
| test_pat | input | 1 | Checkerboard phase select |
| user_rd | input | 1 | Normal read request |
| user_wr | input | 1 | Normal write request, wins over user_rd |
| user_addr | input | ADDR_W | Normal access address |
| user_wdata | input | DATA_W | Normal write data |
| user_rdata | output | DATA_W | Data of the last accepted read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DATA_W | Memory read data, one clock after the address |
| busy | output | 1 | Sweep or test running |
| ready | output | 1 | Last operation completed |
| pass | output | 1 | Result of the last self test |
| test_pending | output | 1 | Self-test request bit, clears itself |

## Verification
If the address counter or the two-clock phase bit goes wrong, the busy window comes out at the wrong length. It also leaves memory words that were never cleared or never patterned, and these show up as soon as the operation ends. A stuck lockout counter or a stuck cancel path changes the number of idle cycles between sweeps, or the cycle in which busy falls, so the error shows within one word-clock window. A corrupt compare pipeline is caught by a memory fault injected at one address, which must bring pass back as 0 at the end of that test. A clean rerun must then report 1.

// File: rtl/dmz_pkg.sv
package dmz_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ZERO,
    SQ_TWR,
    SQ_TRD,
    SQ_TCMP,
    SQ_TEND
  } sq_state_e;

  // Word with every odd (odd_pos=1) or even (odd_pos=0) bit position set
  function automatic logic [31:0] alt_bits(input logic odd_pos);
    logic [31:0] v;
    for (int i = 0; i < 32; i++) begin
      v[i] = odd_pos ? i[0] : ~i[0];
    end
    return v;
  endfunction

endpackage

// File: rtl/dmz_lockout.sv
module dmz_lockout #(
  parameter int LOCK_CYC = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic clear
);
  localparam int LW = $clog2(LOCK_CYC + 1);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LW'(LOCK_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign clear = (cnt_q == '0);
endmodule

// File: rtl/dmz_cmp.sv
module dmz_cmp #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              chk_en,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] expect_w,
  output logic              err
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      err <= 1'b0;
    end else if (chk_en && (rdata != expect_w)) begin
      err <= 1'b1;
    end
  end
endmodule

// File: rtl/dmz_seq.sv
module dmz_seq
  import dmz_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zero_want,
  input  logic              cancel,
  input  logic              lock_clear,
  input  logic              test_want,
  input  logic              test_pat,
  input  logic              acc_busy,
  input  logic              err,
  output logic              start_zero,
  output logic              start_test,
  output logic              zero_done,
  output logic              test_done,
  output logic              zero_active,
  output logic              test_active,
  output logic [ADDR_W-1:0] sw_addr,
  output logic [DATA_W-1:0] sw_wdata,
  output logic              sw_we,
  output logic              chk_en,
  output logic [DATA_W-1:0] chk_exp,
  output logic              pass
);
  localparam logic [31:0]       ODD32  = alt_bits(1'b1);
  localparam logic [31:0]       EVEN32 = alt_bits(1'b0);
  localparam logic [DATA_W-1:0] PAT_ODDB  = ODD32[DATA_W-1:0];
  localparam logic [DATA_W-1:0] PAT_EVENB = EVEN32[DATA_W-1:0];

  sq_state_e         st_q;
  logic [ADDR_W-1:0] cnt_q;
  logic              sub_q;
  logic              pat_q;
  logic              last;
  logic [DATA_W-1:0] exp_now;

  assign last      = (cnt_q == '1);
  assign exp_now   = (pat_q ^ cnt_q[0]) ? PAT_ODDB : PAT_EVENB;

  assign start_zero = (st_q == SQ_IDLE) && zero_want && !cancel && lock_clear && !acc_busy;
  assign start_test = (st_q == SQ_IDLE) && test_want && !start_zero && !acc_busy;
  assign zero_done  = (st_q == SQ_ZERO) && sub_q && last && !cancel;
  assign test_done  = (st_q == SQ_TEND);

  assign zero_active = (st_q == SQ_ZERO);
  assign test_active = (st_q == SQ_TWR) || (st_q == SQ_TRD) ||
                       (st_q == SQ_TCMP) || (st_q == SQ_TEND);

  assign sw_addr  = cnt_q;
  assign sw_we    = ((st_q == SQ_ZERO) || (st_q == SQ_TWR)) && !sub_q;
  assign sw_wdata = (st_q == SQ_TWR) ? exp_now : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_IDLE;
      cnt_q   <= '0;
      sub_q   <= 1'b0;
      pat_q   <= 1'b0;
      chk_en  <= 1'b0;
      chk_exp <= '0;
      pass    <= 1'b0;
    end else begin
      chk_en  <= (st_q == SQ_TRD) && sub_q;
      chk_exp <= exp_now;
      unique case (st_q)
        SQ_IDLE: begin
          cnt_q <= '0;
          sub_q <= 1'b0;
          if (start_zero) begin
            st_q <= SQ_ZERO;
          end else if (start_test) begin
            st_q  <= SQ_TWR;
            pat_q <= test_pat;
            pass  <= 1'b0;
          end
        end
        SQ_ZERO, SQ_TWR, SQ_TRD: begin
          if ((st_q == SQ_ZERO) && cancel) begin
            st_q <= SQ_IDLE;
          end else begin
            sub_q <= ~sub_q;
            if (sub_q) begin
              cnt_q <= cnt_q + 1'b1;
              if (last) begin
                st_q <= (st_q == SQ_ZERO) ? SQ_IDLE :
                        (st_q == SQ_TWR)  ? SQ_TRD  : SQ_TCMP;
              end
            end
          end
        end
        SQ_TCMP: st_q <= SQ_TEND;
        SQ_TEND: begin
          st_q <= SQ_IDLE;
          pass <= !err;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmz_sweep_ctrl.sv
module dmz_sweep_ctrl #(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 14,
  parameter int LOCK_CYC = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              int_mode,
  input  logic              prog_change,
  input  logic              zero_req,
  input  logic              zero_cancel,
  input  logic              test_go,
  input  logic              test_pat,
  input  logic              user_rd,
  input  logic              user_wr,
  input  logic [ADDR_W-1:0] user_addr,
  input  logic [DATA_W-1:0] user_wdata,
  output logic [DATA_W-1:0] user_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              ready,
  output logic              pass,
  output logic              test_pending
);
  logic              zero_pend;
  logic              lock_clear;
  logic              start_zero, start_test, zero_done, test_done;
  logic              zero_active, test_active;
  logic [ADDR_W-1:0] sw_addr;
  logic [DATA_W-1:0] sw_wdata;
  logic              sw_we;
  logic              chk_en;
  logic [DATA_W-1:0] chk_exp;
  logic              err;
  logic [1:0]        acc_q;
  logic              acc_rd_q;
  logic              accept;

  assign busy   = zero_active || test_active;
  assign accept = (user_rd || user_wr) && !busy && !start_zero && !start_test &&
                  (acc_q == 2'd0);

  dmz_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk   (clk),
    .rst   (rst),
    .load  (zero_done),
    .clear (lock_clear)
  );

  dmz_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .clr      (start_test),
    .chk_en   (chk_en),
    .rdata    (mem_rdata),
    .expect_w (chk_exp),
    .err      (err)
  );

  dmz_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .zero_want   (zero_req || zero_pend),
    .cancel      (zero_cancel),
    .lock_clear  (lock_clear),
    .test_want   (test_pending),
    .test_pat    (test_pat),
    .acc_busy    (acc_q != 2'd0),
    .err         (err),
    .start_zero  (start_zero),
    .start_test  (start_test),
    .zero_done   (zero_done),
    .test_done   (test_done),
    .zero_active (zero_active),
    .test_active (test_active),
    .sw_addr     (sw_addr),
    .sw_wdata    (sw_wdata),
    .sw_we       (sw_we),
    .chk_en      (chk_en),
    .chk_exp     (chk_exp),
    .pass        (pass)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_pend    <= 1'b1;
      test_pending <= 1'b0;
      ready        <= 1'b0;
    end else begin
      zero_pend    <= (zero_pend && !start_zero) || (prog_change && int_mode);
      test_pending <= test_go || (test_pending && !test_done);
      if (start_zero || start_test || accept) begin
        ready <= 1'b0;
      end else if (zero_done || test_done || (acc_q == 2'd2)) begin
        ready <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= 2'd0;
      acc_rd_q   <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_we     <= 1'b0;
      user_rdata <= '0;
    end else if (accept) begin
      acc_q     <= 2'd1;
      acc_rd_q  <= !user_wr;
      mem_addr  <= user_addr;
      mem_wdata <= user_wdata;
      mem_we    <= user_wr;
    end else if (acc_q == 2'd1) begin
      acc_q  <= 2'd2;
      mem_we <= 1'b0;
    end else if (acc_q == 2'd2) begin
      acc_q <= 2'd0;
      if (acc_rd_q) begin
        user_rdata <= mem_rdata;
      end
    end else begin
      mem_addr  <= sw_addr;
      mem_wdata <= sw_wdata;
      mem_we    <= sw_we;
    end
  end
endmodule

// File: rtl/dmz_sweep_chk.sv
module dmz_sweep_chk #(
  parameter int DATA_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              zero_cancel,
  input logic              ready,
  input logic              busy,
  input logic              pass,
  input logic              test_pending,
  input logic              zero_active,
  input logic              test_active,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata
);
  AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (rst)
    zero_active && zero_cancel |=> !zero_active); // R4

  AST_CANCEL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    zero_cancel && !zero_active |=> !zero_active); // R4

  AST_ZERO_WDATA: assert property (@(posedge clk) disable iff (rst)
    $past(zero_active) && mem_we |-> mem_wdata == '0); // R2

  AST_TEST_PENDING: assert property (@(posedge clk) disable iff (rst)
    test_active |-> test_pending); // R6

  AST_PASS_LOW_IN_TEST: assert property (@(posedge clk) disable iff (rst)
    test_active |-> !pass); // R7

  AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ready); // R11
endmodule

bind dmz_sweep_ctrl dmz_sweep_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .zero_cancel  (zero_cancel),
  .ready        (ready),
  .busy         (busy),
  .pass         (pass),
  .test_pending (test_pending),
  .zero_active  (zero_active),
  .test_active  (test_active),
  .mem_we       (mem_we),
  .mem_wdata    (mem_wdata)
);

// File: tb/test_dmz_sweep_ctrl.sv
module test_dmz_sweep_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 14;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int LOCK_CYC   = 8;
  localparam int WATCHDOG   = 100000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              int_mode = 1'b0, prog_change = 1'b0;
  logic              zero_req = 1'b0, zero_cancel = 1'b0;
  logic              test_go = 1'b0, test_pat = 1'b0;
  logic              user_rd = 1'b0, user_wr = 1'b0;
  logic [ADDR_W-1:0] user_addr = '0;
  logic [DATA_W-1:0] user_wdata = '0;
  logic [DATA_W-1:0] user_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_we;
  logic [DATA_W-1:0] mem_rdata;
  logic              busy, ready, pass, test_pending;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              fill_go = 1'b0;
  logic [DATA_W-1:0] fill_val = '0;
  logic [DATA_W-1:0] flt_mask = '0;
  localparam int     FLT_ADDR = 5;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmz_sweep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_CYC(LOCK_CYC)) i_dmz_sweep_ctrl (
    .clk(clk), .rst(rst), .int_mode(int_mode), .prog_change(prog_change),
    .zero_req(zero_req), .zero_cancel(zero_cancel), .test_go(test_go), .test_pat(test_pat),
    .user_rd(user_rd), .user_wr(user_wr), .user_addr(user_addr), .user_wdata(user_wdata),
    .user_rdata(user_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .busy(busy), .ready(ready), .pass(pass), .test_pending(test_pending)
  );

  always_ff @(posedge clk) begin
    if (fill_go) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= fill_val;
    end else if (mem_we) begin
      mem[mem_addr] <= (int'(mem_addr) == FLT_ADDR) ? (mem_wdata ^ flt_mask) : mem_wdata;
    end
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog all requirements actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Waits for busy; returns number of negedge samples until seen (0 if never)
  task automatic wait_busy(input int lim, output int lat);
    lat = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (busy) begin lat = i; break; end
    end
  endtask

  // Called right after a sample with busy=1; counts busy samples including it
  task automatic wait_idle(output int n);
    n = 1;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (!busy) break;
      n++;
    end
  endtask

  task automatic fill(input logic [DATA_W-1:0] v);
    fill_val = v; fill_go = 1'b1;
    @(negedge clk);
    fill_go = 1'b0;
  endtask

  task automatic chk_all(input string req, input logic [DATA_W-1:0] v);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== v) bad++;
    chk(req, bad, 0);
  endtask

  task automatic t_reset;
    int n;
    cyc_wait(3);
    rst = 1'b0;
    chk("R1 ready after reset", ready, 0);
    chk("R1 pass after reset", pass, 0);
    chk("R1 busy at reset release", busy, 0);
    @(negedge clk);
    chk("R1 sweep starts after reset", busy, 1);
    wait_idle(n);
    chk("R2 sweep length", n, 2*DEPTH);
    chk_all("R2 memory cleared after reset", '0);
    chk("R11 ready after sweep", ready, 1);
  endtask

  task automatic t_zero_complete;
    int lat, n;
    cyc_wait(LOCK_CYC + 4);
    fill(14'h1234);
    zero_req = 1'b1;
    @(negedge clk);
    zero_req = 1'b0;
    chk("R2 sweep starts on request", busy, 1);
    chk("R11 ready low while sweeping", ready, 0);
    wait_idle(n);
    chk("R2 sweep runs to end after request drops", n, 2*DEPTH);
    chk_all("R2 every word zero", '0);
    wait_busy(3*LOCK_CYC, lat);
    chk("R3 no sweep without request", lat, 0);
  endtask

  task automatic t_repeat;
    int lat, n, lows;
    zero_req = 1'b1;
    wait_busy(4, lat);
    chk("R3 held request starts sweep", lat, 1);
    wait_idle(n);
    lows = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (busy) break;
      lows++;
    end
    chk("R3 lockout gap", lows, LOCK_CYC + 1);
    zero_req = 1'b0;
    wait_idle(n);
    chk("R2 repeated sweep length", n, 2*DEPTH);
    wait_busy(3*LOCK_CYC, lat);
    chk("R3 sweeps stop after request drops", lat, 0);
  endtask

  task automatic t_cancel;
    int lat, n;
    fill(14'h0F0F);
    zero_req = 1'b1;
    @(negedge clk);
    zero_req = 1'b0;
    cyc_wait(10);
    zero_cancel = 1'b1;
    @(negedge clk);
    chk("R4 cancel stops sweep", busy, 0);
    chk("R4 untouched top word", mem[DEPTH-1], 14'h0F0F);
    chk("R4 cleared low word", mem[0], 0);
    chk("R11 ready stays low after cancel", ready, 0);
    zero_req = 1'b1;
    wait_busy(20, lat);
    chk("R4 cancel blocks request", lat, 0);
    zero_cancel = 1'b0;
    wait_busy(4, lat);
    chk("R4 sweep resumes after cancel drops", lat, 1);
    zero_req = 1'b0;
    wait_idle(n);
    chk_all("R4 full sweep after cancel released", '0);
    cyc_wait(LOCK_CYC + 4);
  endtask

  task automatic user_op(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    user_addr = a; user_wdata = d; user_wr = wr; user_rd = !wr;
    @(negedge clk);
    user_wr = 1'b0; user_rd = 1'b0;
  endtask

  task automatic t_user;
    user_op(1'b1, 6'd7, 14'h1ABC);
    chk("R9 ready low during access", ready, 0);
    cyc_wait(2);
    chk("R9 ready after write", ready, 1);
    chk("R9 word written", mem[7], 14'h1ABC);
    user_op(1'b0, 6'd7, '0);
    cyc_wait(2);
    chk("R9 read data", user_rdata, 14'h1ABC);
    chk("R9 ready after read", ready, 1);
  endtask

  task automatic t_ignore;
    int n;
    zero_req = 1'b1;
    @(negedge clk);
    zero_req = 1'b0;
    cyc_wait(2*DEPTH - 8);
    user_op(1'b1, 6'd0, 14'h0555);
    user_op(1'b0, 6'd7, '0);
    wait_idle(n);
    cyc_wait(3);
    chk("R8 write while busy dropped", mem[0], 0);
    chk("R8 read while busy dropped", user_rdata, 14'h1ABC);
  endtask

  task automatic run_test(input logic pat, input string req, output int n);
    int lat;
    test_pat = pat; test_go = 1'b1;
    @(negedge clk);
    test_go = 1'b0;
    chk({req, " pending set"}, test_pending, 1);
    wait_busy(4, lat);
    chk({req, " start latency"}, lat, 1);
    chk("R7 pass cleared at start", pass, 0);
    wait_idle(n);
  endtask

  task automatic t_test(input logic pat);
    int n, bad;
    logic [DATA_W-1:0] ev, od;
    run_test(pat, "R6", n);
    chk("R6 test length", n, 4*DEPTH + 2);
    chk("R6 pending self-clears", test_pending, 0);
    chk("R7 pass on clean memory", pass, 1);
    chk("R11 ready after test", ready, 1);
    ev = pat ? 14'h2AAA : 14'h1555;
    od = pat ? 14'h1555 : 14'h2AAA;
    bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== (i[0] ? od : ev)) bad++;
    chk("R5 checkerboard phase", bad, 0);
  endtask

  task automatic t_fault;
    int n;
    flt_mask = 14'h0004;
    run_test(1'b1, "R7", n);
    chk("R7 pass low on fault", pass, 0);
    flt_mask = '0;
    run_test(1'b1, "R7", n);
    chk("R7 pass back on clean rerun", pass, 1);
  endtask

  task automatic t_nocancel;
    int n, lat;
    test_pat = 1'b0; test_go = 1'b1;
    @(negedge clk);
    test_go = 1'b0;
    wait_busy(4, lat);
    cyc_wait(5);
    zero_cancel = 1'b1; zero_req = 1'b1;
    wait_idle(n);
    chk("R6 test not cancelled", n, 4*DEPTH + 2 - 5);
    chk("R6 uncancelled test passes", pass, 1);
    zero_req = 1'b0;
    @(negedge clk);
    zero_cancel = 1'b0;
    cyc_wait(2);
    chk("R4 no sweep while cancel held", busy, 0);
  endtask

  task automatic t_prog;
    int lat, n;
    cyc_wait(LOCK_CYC + 4);
    int_mode = 1'b0; prog_change = 1'b1;
    @(negedge clk);
    prog_change = 1'b0;
    wait_busy(12, lat);
    chk("R10 external mode ignores program change", lat, 0);
    int_mode = 1'b1; prog_change = 1'b1;
    @(negedge clk);
    prog_change = 1'b0;
    wait_busy(4, lat);
    chk("R10 internal mode program change starts sweep", lat, 1);
    wait_idle(n);
    chk("R10 sweep length", n, 2*DEPTH);
  endtask

  initial begin
    t_reset();
    t_zero_complete();
    t_repeat();
    cyc_wait(LOCK_CYC + 4);
    t_cancel();
    t_user();
    t_ignore();
    t_test(1'b1);
    t_test(1'b0);
    t_fault();
    t_nocancel();
    t_prog();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule